// File: doc/BRIEF.md
# Boundary-Splitting Load/Store Unit

This unit sits between a processor pipeline and a data memory port that uses a request/grant handshake followed by a response-valid beat. The core hands it one load or store at a time, with a byte address, write data, an access size (byte, half or word), a sign-extension flag and a protection-fault flag from an external checker. The unit registers the request and drives only word-aligned addresses on the memory port. It selects sub-word lanes through byte enables alone.

An access whose bytes cross into the following word becomes two consecutive word transactions. The load bytes from the first response are held and merged with those from the second, and the result is zero- or sign-extended. Errors from either half, and protection faults, are gathered and reported once, at the single completion pulse, together with the address of the failing part. A protection-faulted access never reaches the memory port. It walks through the same states as a granted access and completes as an error.

Top module: `lsu_split`

## Requirements
- R1: Every address driven on `bus_addr_o` while `bus_req_o` is high has its two low bits at zero; the first transaction targets the word holding the requested address.
- R2: An access that fits in one word (a byte; a half at offset 0, 1 or 2; a word at offset 0) makes exactly one transaction. Its byte enables are the size mask shifted left by the address offset (size 0 = byte, mask 0001; size 1 = half, mask 0011; size 2 = word, mask 1111), and store byte j goes to lane offset+j.
- R3: A word at a nonzero offset, or a half at offset 3, makes two transactions. The second targets the first word address plus 4, and its byte enables and write lanes cover only the bytes that spill into that word. Both parts use the offset of the original address.
- R4: An error response on the first part of a split access does not stop the second part from being requested.
- R5: `done_o` pulses for one cycle with the final response, and `err_o` is high with it when any part answered with an error; no error is signalled earlier.
- R6: `bus_err_i` is ignored in any cycle where `bus_rvalid_i` is low.
- R7: With `prot_fault_i` set at acceptance, `bus_req_o` stays low for the whole access. The unit still completes through its normal states, and `done_o` arrives with `err_o` high.
- R8: A latched protection fault is cleared on return to idle, so the next access runs on the bus normally and completes without error.
- R9: A load returns the addressed bytes in the low end of `rdata_o`, with bytes of both parts merged for a split access, zero-extended when `sext_i` is low and sign-extended when it is high.
- R10: With an error, `err_addr_o` is the requested address when the first or only part failed or the access was faulted, and the second word address (first word address plus 4) when only the second part failed.
- R11: `ready_o` is high only in idle, a request is taken only then, and a response beat is legal only while the unit waits for one on an unfaulted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Core request, taken when `ready_o` is high |
| ready_o | output | 1 | Unit idle and able to take a request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 half, 2 word |
| sext_i | input | 1 | Sign-extend load data |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data, low-aligned |
| prot_fault_i | input | 1 | Protection checker flagged this access |
| done_o | output | 1 | Access complete (one cycle) |
| err_o | output | 1 | Completed access had an error |
| err_addr_o | output | ADDR_W | Address of the failing part |
| rdata_o | output | 32 | Aligned, extended load data |
| bus_req_o | output | 1 | Memory request |
| bus_gnt_i | input | 1 | Memory grant |
| bus_addr_o | output | ADDR_W | Word-aligned memory address |
| bus_we_o | output | 1 | Memory write |
| bus_be_o | output | 4 | Memory byte enables |
| bus_wdata_o | output | 32 | Memory write data, lane-aligned |
| bus_rvalid_i | input | 1 | Memory response valid |
| bus_rdata_i | input | 32 | Memory read data |
| bus_err_i | input | 1 | Memory response error |

## Verification
A wrong state in the controller shows at the memory port within one cycle. A missing or extra request appears, or the second address is stale, or a faulted access drives the bus. A lost first-part error or stale held read data shows only at the completion cycle, through `err_o`, `err_addr_o` and `rdata_o`. The stimulus therefore pairs each split pattern with error placement on either part. It follows a faulted access with a clean one, so that a fault flag left set would corrupt the very next completion.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  // GNT1/RSP1: first part; GNT2/RSP: second or only part
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GNT1 = 3'd1,
    ST_RSP1 = 3'd2,
    ST_GNT2 = 3'd3,
    ST_RSP  = 3'd4
  } state_e;
endpackage

// File: rtl/lsu_lanes.sv
// Byte-enable and write-lane placement for both parts of an access.
module lsu_lanes
  import lsu_split_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_lo_o,
  output logic [LANES-1:0]  be_hi_o,
  output logic [WORD_W-1:0] wd_lo_o,
  output logic [WORD_W-1:0] wd_hi_o,
  output logic              split_o
);
  logic [LANES-1:0]    mask;
  logic [2*LANES-1:0]  be_all;
  logic [2*WORD_W-1:0] wd_all;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = LANES'(1);
      SZ_HALF: mask = LANES'(3);
      default: mask = '1;
    endcase
  end

  // Two-word window: low half is the first word, high half the spill
  assign be_all  = {{LANES{1'b0}}, mask} << off_i;
  assign wd_all  = {{WORD_W{1'b0}}, wdata_i} << {off_i, 3'b000};
  assign be_lo_o = be_all[LANES-1:0];
  assign be_hi_o = be_all[2*LANES-1:LANES];
  assign wd_lo_o = wd_all[WORD_W-1:0];
  assign wd_hi_o = wd_all[2*WORD_W-1:WORD_W];
  assign split_o = |be_hi_o;
endmodule

// File: rtl/lsu_rdata.sv
// Holds first-part load data, merges with the final beat, extends.
module lsu_rdata
  import lsu_split_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              split_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0]   lo_q;
  logic [2*WORD_W-1:0] merged;
  logic [WORD_W-1:0]   aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
    end else if (cap_i) begin
      lo_q <= rdata_i;
    end
  end

  assign merged  = {rdata_i, (split_i ? lo_q : rdata_i)} >> {off_i, 3'b000};
  assign aligned = merged[WORD_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){sext_i & aligned[7]}}, aligned[7:0]};
      SZ_HALF: data_o = {{(WORD_W-16){sext_i & aligned[15]}}, aligned[15:0]};
      default: data_o = aligned;
    endcase
  end
endmodule

// File: rtl/lsu_ctrl.sv
// Access sequencer: grant/response tracking, error and fault latching.
module lsu_ctrl
  import lsu_split_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic prot_fault_i,
  input  logic split_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  input  logic err_i,
  output logic ready_o,
  output logic accept_o,
  output logic bus_req_o,
  output logic part2_o,
  output logic cap_o,
  output logic done_o,
  output logic err_o,
  output logic err_first_o,
  output logic fault_o,
  output logic wait_rsp_o,
  output logic part1_wait_o
);
  state_e state_q, state_d;
  logic   fault_q, fault_d;
  logic   err1_q, err1_d;
  logic   in_rsp, rsp_ev, granted;

  assign in_rsp  = (state_q == ST_RSP1) || (state_q == ST_RSP);
  // A faulted access advances as if every beat had been granted/answered
  assign rsp_ev  = in_rsp && (fault_q || rvalid_i);
  assign granted = fault_q || gnt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i)   state_d = ST_GNT1;
      ST_GNT1: if (granted) state_d = split_i ? ST_RSP1 : ST_RSP;
      ST_RSP1: if (rsp_ev)  state_d = ST_GNT2;
      ST_GNT2: if (granted) state_d = ST_RSP;
      ST_RSP:  if (rsp_ev)  state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    fault_d = fault_q;
    err1_d  = err1_q;
    if (accept_o) begin
      fault_d = prot_fault_i;
      err1_d  = 1'b0;
    end else if (state_d == ST_IDLE) begin
      fault_d = 1'b0;
      err1_d  = 1'b0;
    end else if ((state_q == ST_RSP1) && rvalid_i && err_i) begin
      err1_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      err1_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      err1_q  <= err1_d;
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign accept_o     = ready_o && req_i;
  assign bus_req_o    = ((state_q == ST_GNT1) || (state_q == ST_GNT2)) && !fault_q;
  assign part2_o      = (state_q == ST_GNT2);
  assign cap_o        = (state_q == ST_RSP1) && rvalid_i;
  assign done_o       = (state_q == ST_RSP) && rsp_ev;
  assign err_o        = done_o && (fault_q || err1_q || (rvalid_i && err_i));
  assign err_first_o  = fault_q || err1_q || !split_i;
  assign fault_o      = fault_q;
  assign wait_rsp_o   = in_rsp && !fault_q;
  assign part1_wait_o = (state_q == ST_RSP1) && !fault_q;
endmodule

// File: rtl/lsu_split.sv
module lsu_split
  import lsu_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              prot_fault_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_we_o,
  output logic [LANES-1:0]  bus_be_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_rvalid_i,
  input  logic [WORD_W-1:0] bus_rdata_i,
  input  logic              bus_err_i
);
  localparam int unsigned IDX_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addr_q;
  logic              we_q, sext_q;
  logic [1:0]        size_q;
  logic [WORD_W-1:0] wdata_q;

  logic              accept, part2, cap, split, err_first;
  logic              fault_q, wait_rsp, part1_wait;
  logic [LANES-1:0]  be_lo, be_hi;
  logic [WORD_W-1:0] wd_lo, wd_hi;
  logic [IDX_W-1:0]  word_idx, word_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= 2'd0;
      sext_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      size_q  <= size_i;
      sext_q  <= sext_i;
      wdata_q <= wdata_i;
    end
  end

  lsu_lanes u_lanes (
    .off_i   (addr_q[OFF_W-1:0]),
    .size_i  (size_q),
    .wdata_i (wdata_q),
    .be_lo_o (be_lo),
    .be_hi_o (be_hi),
    .wd_lo_o (wd_lo),
    .wd_hi_o (wd_hi),
    .split_o (split)
  );

  lsu_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .prot_fault_i (prot_fault_i),
    .split_i      (split),
    .gnt_i        (bus_gnt_i),
    .rvalid_i     (bus_rvalid_i),
    .err_i        (bus_err_i),
    .ready_o      (ready_o),
    .accept_o     (accept),
    .bus_req_o    (bus_req_o),
    .part2_o      (part2),
    .cap_o        (cap),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_first_o  (err_first),
    .fault_o      (fault_q),
    .wait_rsp_o   (wait_rsp),
    .part1_wait_o (part1_wait)
  );

  lsu_rdata u_rdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .rdata_i (bus_rdata_i),
    .split_i (split),
    .off_i   (addr_q[OFF_W-1:0]),
    .size_i  (size_q),
    .sext_i  (sext_q),
    .data_o  (rdata_o)
  );

  assign word_idx    = addr_q[ADDR_W-1:OFF_W];
  assign word_nxt    = word_idx + IDX_W'(1);
  assign bus_addr_o  = {(part2 ? word_nxt : word_idx), {OFF_W{1'b0}}};
  assign bus_be_o    = part2 ? be_hi : be_lo;
  assign bus_wdata_o = part2 ? wd_hi : wd_lo;
  assign bus_we_o    = we_q;
  assign err_addr_o  = err_first ? addr_q : {word_nxt, {OFF_W{1'b0}}};
endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk
  import lsu_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [LANES-1:0]  bus_be_o,
  input logic              bus_rvalid_i,
  input logic              bus_err_i,
  input logic              fault_q,
  input logic              wait_rsp,
  input logic              part1_wait
);
  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[OFF_W-1:0] == '0)); // R1

  AST_REQ_HELD_TO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o))); // R2

  AST_BE_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_be_o != '0)); // R3

  AST_PART2_AFTER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part1_wait && bus_rvalid_i && bus_err_i) |=> bus_req_o); // R4

  AST_FAULT_NO_BUS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> !bus_req_o); // R7

  AST_FAULT_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !fault_q); // R8

  AST_RSP_ONLY_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_i |-> wait_rsp); // R11
endmodule

bind lsu_split lsu_split_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_addr_o   (bus_addr_o),
  .bus_be_o     (bus_be_o),
  .bus_rvalid_i (bus_rvalid_i),
  .bus_err_i    (bus_err_i),
  .fault_q      (fault_q),
  .wait_rsp     (wait_rsp),
  .part1_wait   (part1_wait)
);

// File: tb/tb_lsu_split.sv
`timescale 1ns/1ps
module tb_lsu_split;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_i, we_i, sext_i, prot_fault_i;
  logic [1:0]  size_i;
  logic [31:0] addr_i, wdata_i;
  logic        ready_o, done_o, err_o;
  logic [31:0] err_addr_o, rdata_o;
  logic        bus_req_o, bus_gnt_i, bus_we_o, bus_rvalid_i, bus_err_i;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic [3:0]  bus_be_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lsu_split dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
    .we_i(we_i), .size_i(size_i), .sext_i(sext_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .prot_fault_i(prot_fault_i), .done_o(done_o),
    .err_o(err_o), .err_addr_o(err_addr_o), .rdata_o(rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_addr_o(bus_addr_o),
    .bus_we_o(bus_we_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
    .bus_rvalid_i(bus_rvalid_i), .bus_rdata_i(bus_rdata_i), .bus_err_i(bus_err_i)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        we;
    logic [1:0]  size;
    logic        sext;
    logic        fault;
    logic        err1;
    logic        err2;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h100, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // word aligned load
    '{32'h101, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},  // byte sext
    '{32'h102, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // half sext
    '{32'h103, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // half split zext
    '{32'h105, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // word split
    '{32'h106, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // store half
    '{32'h107, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // store word split
    '{32'h101, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0},  // split, first part error
    '{32'h10B, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},  // split, second part error
    '{32'h10C, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // faulted store
    '{32'h10D, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // clean after fault
    '{32'h102, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // faulted split load
    '{32'h10F, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1},  // store split both errors
    '{32'h103, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // single-part error
    '{32'h10E, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}   // half sext offset 2
  };

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd29;
    return p ^ 8'hB6;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] w);
    return {mem_byte(w + 32'd3), mem_byte(w + 32'd2), mem_byte(w + 32'd1), mem_byte(w)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_gnt_i    = 1'b0;
    bus_rvalid_i = 1'b0;
    bus_err_i    = 1'b1;          // garbage while no response (R6)
    bus_rdata_i  = 32'hDEAD_BEEF;
  endtask

  task automatic run_vec(input vec_t v, input bit prev_fault);
    logic [31:0] taddr [3];
    logic [3:0]  tbe   [3];
    logic [31:0] twd   [3];
    logic [3:0]  ebe   [2];
    logic [31:0] ewd   [2];
    logic        errs  [2];
    logic [31:0] lv, mask32, wd, eaddr;
    int off, nb, exp_ntx, ntx, p;
    bit split, pend, got, busy_ok, exp_err;
    logic d_err;
    logic [31:0] d_eaddr, d_data;
    string rq;

    off = int'(v.addr[1:0]);
    nb = 1 << v.size;
    split = (off + nb) > 4;
    exp_ntx = v.fault ? 0 : (split ? 2 : 1);
    errs[0] = v.err1; errs[1] = v.err2;
    wd = 32'h9E37_79B9 ^ v.addr;
    ebe[0] = '0; ebe[1] = '0; ewd[0] = '0; ewd[1] = '0; lv = '0;
    for (int j = 0; j < nb; j++) begin
      p = off + j;
      ebe[p / 4][p % 4] = 1'b1;
      ewd[p / 4][8 * (p % 4) +: 8] = wd[8 * j +: 8];
      lv[8 * j +: 8] = mem_byte(v.addr + 32'(j));
    end
    if (v.sext && lv[8 * nb - 1])
      for (int j = nb; j < 4; j++) lv[8 * j +: 8] = 8'hFF;
    exp_err = v.fault | v.err1 | (split & v.err2);
    eaddr = (v.fault | v.err1 | !split) ? v.addr : ({v.addr[31:2], 2'b00} + 32'd4);

    req_i = 1'b1; we_i = v.we; size_i = v.size; sext_i = v.sext;
    addr_i = v.addr; wdata_i = wd; prot_fault_i = v.fault;
    @(posedge clk); @(negedge clk);
    req_i = 1'b0; prot_fault_i = 1'b0;
    ntx = 0; pend = 0; got = 0; busy_ok = 1;
    d_err = 1'b0; d_eaddr = '0; d_data = '0;
    for (int cyc = 0; cyc < 30 && !got; cyc++) begin
      idle_bus();
      if (pend) begin
        bus_rvalid_i = 1'b1;
        bus_err_i    = errs[ntx - 1];
        bus_rdata_i  = mem_word(taddr[ntx - 1]);
        pend = 0;
      end
      #1;
      if (ready_o) busy_ok = 0;
      if (bus_req_o && ntx < 3) begin
        taddr[ntx] = bus_addr_o; tbe[ntx] = bus_be_o; twd[ntx] = bus_wdata_o;
        bus_gnt_i = 1'b1;
        pend = 1;
        ntx++;
      end
      if (done_o) begin
        got = 1; d_err = err_o; d_eaddr = err_addr_o; d_data = rdata_o;
      end
      @(posedge clk); @(negedge clk);
    end
    idle_bus();
    #1;

    chk(got, "R5", "completion seen", 32'(got), 32'd1);
    chk(busy_ok && ready_o, "R11", "ready only in idle", {31'd0, busy_ok}, 32'd1);
    rq = v.fault ? "R7" : (split ? (v.err1 ? "R4" : "R3") : "R2");
    chk(ntx == exp_ntx, rq, "transaction count", 32'(ntx), 32'(exp_ntx));
    for (int k = 0; k < 2; k++) begin
      if (k < ntx && k < exp_ntx) begin
        rq = (k == 0) ? "R1" : "R3";
        chk(taddr[k] == ({v.addr[31:2], 2'b00} + 32'(4 * k)), rq, "bus address",
            taddr[k], {v.addr[31:2], 2'b00} + 32'(4 * k));
        rq = split ? "R3" : "R2";
        chk(tbe[k] == ebe[k], rq, "byte enables", {28'd0, tbe[k]}, {28'd0, ebe[k]});
        if (v.we) begin
          for (int l = 0; l < 4; l++) mask32[8 * l +: 8] = {8{ebe[k][l]}};
          chk(((twd[k] ^ ewd[k]) & mask32) == 0, rq, "write lanes", twd[k] & mask32, ewd[k]);
        end
      end
    end
    rq = v.fault ? "R7" : (prev_fault ? "R8" : (exp_err ? "R5" : "R6"));
    chk(d_err == exp_err, rq, "error flag", {31'd0, d_err}, {31'd0, exp_err});
    if (exp_err)
      chk(d_eaddr == eaddr, "R10", "error address", d_eaddr, eaddr);
    if (!v.we && !exp_err)
      chk(d_data == lv, "R9", "load data", d_data, lv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    req_i = 1'b0; we_i = 1'b0; size_i = 2'd0; sext_i = 1'b0;
    addr_i = '0; wdata_i = '0; prot_fault_i = 1'b0;
    idle_bus();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready_o == 1'b1, "R11", "reset ready", {31'd0, ready_o}, 32'd1);
    chk(bus_req_o == 1'b0, "R1", "reset bus request", {31'd0, bus_req_o}, 32'd0);
    chk(done_o == 1'b0, "R5", "reset done", {31'd0, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i], (i > 0) ? VECS[i - 1].fault : 1'b0);

    // Back-to-back clean access after a faulted split load (R8)
    run_vec('{32'h102, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, 1'b0);
    run_vec('{32'h102, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule